// File: doc/BRIEF.md
# Six-Channel Set/Clear Pulse Generator

The block produces six pulse outputs from one shared up-counter. Each channel holds two compare values: when the counter reaches the first one the output switches on, and when it reaches the second one the output switches off. Because the two edges are set on their own, the pulse can start and end anywhere in the period. A pulse can also wrap across the period boundary when the switch-off value is below the switch-on value.

Software reaches the block through a word-addressed register port with a single write strobe and combinational read data. Compare values and the period are written to shadow registers. On every counter wrap, all shadows are copied into the working registers together, so a period that has already started always finishes with the values it began with. Each edge event sets a sticky flag. A mask picks which flags drive the single interrupt line.

Top module: `pwm_set_clear`

## Requirements
- R1: After reset the counter reads 0. While running it advances by one each clock, and in the clock after it equals the working period it returns to 0. It reads at word address 0x01, and bits 31:16 read as 0.
- R2: Bit 0 of address 0x00 is the run enable and resets to 0. While it is 0 the counter keeps its value, no flags are set, and every output is low from the next clock on.
- R3: When the counter equals channel n's working switch-on value, output n is high in the next clock, and switch-on flag n (bit n of address 0x03) is set.
- R4: When the counter equals channel n's working switch-off value, output n is low in the next clock, and switch-off flag n (bit 8+n of address 0x03) is set. When both values match in the same clock, the output goes low.
- R5: Writes to the period (0x02), the switch-on values (0x10+n) or the switch-off values (0x18+n) do not change the working values until the next counter wrap. At the wrap all of them take effect together.
- R6: Reading 0x02, 0x10+n or 0x18+n returns the last value written to the 16-bit shadow, with bits 31:16 as 0. All of these reset to 0.
- R7: Flags stay set until a 1 is written to their bit at 0x03. If a flag is set and cleared in the same clock, the set wins.
- R8: irq_o is high exactly when some flag at 0x03 is set and the bit at the same position in the mask register 0x04 is also 1. The mask resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 6 | Channel outputs, high is active |
| irq_o | output | 1 | Masked OR of all flags |

## Verification
The hardest case to reach is a compare-value write that lands partway through a running period. To cover it, the readback must already show the new value while the output still follows the old one until the wrap. The stimulus sets short random periods and mixes register writes in at random clocks, so writes fall before, on and after compare points and on the wrap clock itself. Directed steps add an equal switch-on/switch-off pair, a pulse that wraps across the period boundary, and a readback written mid-period.

// File: rtl/pwm_sc_pkg.sv
package pwm_sc_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned REG_DW = 32;
  // channel n of the falling-edge flag/mask sits at this bit offset
  localparam int unsigned DEA_OFS = 8;
  localparam logic [REG_AW-1:0] A_CTRL     = 6'h00;
  localparam logic [REG_AW-1:0] A_CNT      = 6'h01;
  localparam logic [REG_AW-1:0] A_PER      = 6'h02;
  localparam logic [REG_AW-1:0] A_FLAG     = 6'h03;
  localparam logic [REG_AW-1:0] A_MASK     = 6'h04;
  localparam logic [REG_AW-1:0] A_ACT_BASE = 6'h10;
  localparam logic [REG_AW-1:0] A_DEA_BASE = 6'h18;
endpackage

// File: rtl/pwm_sc_regs.sv
module pwm_sc_regs
  import pwm_sc_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [REG_AW-1:0]              addr_i,
  input  logic [REG_DW-1:0]              wdata_i,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic [NUM_CH-1:0]              flag_a_i,
  input  logic [NUM_CH-1:0]              flag_d_i,
  output logic                           run_o,
  output logic [CNT_W-1:0]               per_sh_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   act_sh_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   dea_sh_o,
  output logic [NUM_CH-1:0]              mask_a_o,
  output logic [NUM_CH-1:0]              mask_d_o,
  output logic [NUM_CH-1:0]              clr_a_o,
  output logic [NUM_CH-1:0]              clr_d_o,
  output logic [REG_DW-1:0]              rdata_o
);
  logic unused_wbits;
  assign unused_wbits = ^wdata_i[REG_DW-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b0;
      per_sh_o <= '0;
      act_sh_o <= '0;
      dea_sh_o <= '0;
      mask_a_o <= '0;
      mask_d_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: run_o    <= wdata_i[0];
        A_PER:  per_sh_o <= wdata_i[CNT_W-1:0];
        A_MASK: begin
          mask_a_o <= wdata_i[NUM_CH-1:0];
          mask_d_o <= wdata_i[DEA_OFS +: NUM_CH];
        end
        default: begin
          for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr_i == A_ACT_BASE + REG_AW'(ch)) act_sh_o[ch] <= wdata_i[CNT_W-1:0];
            if (addr_i == A_DEA_BASE + REG_AW'(ch)) dea_sh_o[ch] <= wdata_i[CNT_W-1:0];
          end
        end
      endcase
    end
  end

  always_comb begin
    clr_a_o = '0;
    clr_d_o = '0;
    if (we_i && addr_i == A_FLAG) begin
      clr_a_o = wdata_i[NUM_CH-1:0];
      clr_d_o = wdata_i[DEA_OFS +: NUM_CH];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[0] = run_o;
      A_CNT:  rdata_o[CNT_W-1:0] = cnt_i;
      A_PER:  rdata_o[CNT_W-1:0] = per_sh_o;
      A_FLAG: begin
        rdata_o[NUM_CH-1:0]        = flag_a_i;
        rdata_o[DEA_OFS +: NUM_CH] = flag_d_i;
      end
      A_MASK: begin
        rdata_o[NUM_CH-1:0]        = mask_a_o;
        rdata_o[DEA_OFS +: NUM_CH] = mask_d_o;
      end
      default: begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
          if (addr_i == A_ACT_BASE + REG_AW'(ch)) rdata_o[CNT_W-1:0] = act_sh_o[ch];
          if (addr_i == A_DEA_BASE + REG_AW'(ch)) rdata_o[CNT_W-1:0] = dea_sh_o[ch];
        end
      end
    endcase
  end
endmodule

// File: rtl/pwm_sc_timebase.sv
module pwm_sc_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_sh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_act_o,
  output logic             wrap_o
);
  assign wrap_o = run_i && (cnt_o == per_act_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      per_act_o <= '0;
    end else if (wrap_o) begin
      cnt_o     <= '0;
      per_act_o <= per_sh_i;
    end else if (run_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_sc_channel.sv
module pwm_sc_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] act_sh_i,
  input  logic [CNT_W-1:0] dea_sh_i,
  input  logic             clr_a_i,
  input  logic             clr_d_i,
  output logic [CNT_W-1:0] act_o,
  output logic [CNT_W-1:0] dea_o,
  output logic             pwm_o,
  output logic             flag_a_o,
  output logic             flag_d_o
);
  logic hit_a, hit_d;
  assign hit_a = run_i && (cnt_i == act_o);
  assign hit_d = run_i && (cnt_i == dea_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o    <= '0;
      dea_o    <= '0;
      pwm_o    <= 1'b0;
      flag_a_o <= 1'b0;
      flag_d_o <= 1'b0;
    end else begin
      if (wrap_i) begin
        act_o <= act_sh_i;
        dea_o <= dea_sh_i;
      end
      // switch-off has priority over switch-on
      if (!run_i || hit_d) pwm_o <= 1'b0;
      else if (hit_a)      pwm_o <= 1'b1;
      flag_a_o <= (flag_a_o & ~clr_a_i) | hit_a;
      flag_d_o <= (flag_d_o & ~clr_d_i) | hit_d;
    end
  end
endmodule

// File: rtl/pwm_set_clear.sv
module pwm_set_clear
  import pwm_sc_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);
  logic                         run_q, wrap;
  logic [CNT_W-1:0]             cnt_q, per_sh, per_act;
  logic [NUM_CH-1:0][CNT_W-1:0] act_sh, dea_sh, act_val, dea_val;
  logic [NUM_CH-1:0]            mask_a, mask_d, clr_a, clr_d, flag_a, flag_d;

  pwm_sc_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .flag_a_i(flag_a), .flag_d_i(flag_d),
    .run_o(run_q), .per_sh_o(per_sh), .act_sh_o(act_sh), .dea_sh_o(dea_sh),
    .mask_a_o(mask_a), .mask_d_o(mask_d), .clr_a_o(clr_a), .clr_d_o(clr_d),
    .rdata_o
  );

  pwm_sc_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .run_i(run_q), .per_sh_i(per_sh),
    .cnt_o(cnt_q), .per_act_o(per_act), .wrap_o(wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_sc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .run_i(run_q), .wrap_i(wrap), .cnt_i(cnt_q),
      .act_sh_i(act_sh[ch]), .dea_sh_i(dea_sh[ch]),
      .clr_a_i(clr_a[ch]), .clr_d_i(clr_d[ch]),
      .act_o(act_val[ch]), .dea_o(dea_val[ch]),
      .pwm_o(pwm_o[ch]), .flag_a_o(flag_a[ch]), .flag_d_o(flag_d[ch])
    );
  end

  assign irq_o = |{flag_a & mask_a, flag_d & mask_d};
endmodule

// File: rtl/pwm_set_clear_chk.sv
module pwm_set_clear_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         run,
  input logic [CNT_W-1:0]             cnt,
  input logic [CNT_W-1:0]             per,
  input logic [NUM_CH-1:0][CNT_W-1:0] act,
  input logic [NUM_CH-1:0][CNT_W-1:0] dea,
  input logic [NUM_CH-1:0]            pwm,
  input logic [NUM_CH-1:0]            flag_a,
  input logic [NUM_CH-1:0]            flag_d
);
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt != per) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R1
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt == per) |=> cnt == '0);
  // R2
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(cnt) && pwm == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R3
    rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && cnt == act[ch] && cnt != dea[ch]) |=> pwm[ch] && flag_a[ch]);
    // R4
    fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && cnt == dea[ch]) |=> !pwm[ch] && flag_d[ch]);
    // R5
    hold_work_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(run && cnt == per) |=> $stable(act[ch]) && $stable(dea[ch]));
  end
endmodule

bind pwm_set_clear pwm_set_clear_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run_q), .cnt(cnt_q), .per(per_act),
  .act(act_val), .dea(dea_val), .pwm(pwm_o), .flag_a(flag_a), .flag_d(flag_d)
);

// File: tb/sim_pwm_set_clear.sv
module sim_pwm_set_clear;
  localparam logic [5:0] A_CTRL = 6'h00, A_CNT = 6'h01, A_PER = 6'h02,
                         A_FLAG = 6'h03, A_MASK = 6'h04, A_ACT = 6'h10, A_DEA = 6'h18;

  logic        clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [5:0]  pwm_o;
  logic        irq_o;

  int errors = 0, checks = 0;
  bit done = 0;

  pwm_set_clear u0 (.clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .pwm_o, .irq_o);

  always #5 clk_i = ~clk_i;

  // reference state
  logic        m_run;
  logic [15:0] m_cnt, m_per_a, m_per_s;
  logic [15:0] m_act_a [6], m_act_s [6], m_dea_a [6], m_dea_s [6];
  logic [5:0]  m_out, m_fa, m_fd, m_ma, m_md;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    logic [31:0] r = '0;
    case (a)
      A_CTRL: r[0] = m_run;
      A_CNT:  r[15:0] = m_cnt;
      A_PER:  r[15:0] = m_per_s;
      A_FLAG: begin r[5:0] = m_fa; r[13:8] = m_fd; end
      A_MASK: begin r[5:0] = m_ma; r[13:8] = m_md; end
      default: for (int c = 0; c < 6; c++) begin
        if (a == A_ACT + 6'(c)) r[15:0] = m_act_s[c];
        if (a == A_DEA + 6'(c)) r[15:0] = m_dea_s[c];
      end
    endcase
    return r;
  endfunction

  function automatic logic exp_irq();
    return |{m_fa & m_ma, m_fd & m_md};
  endfunction

  task automatic model_reset();
    m_run = 0; m_cnt = 0; m_per_a = 0; m_per_s = 0;
    m_out = 0; m_fa = 0; m_fd = 0; m_ma = 0; m_md = 0;
    for (int c = 0; c < 6; c++) begin
      m_act_a[c] = 0; m_act_s[c] = 0; m_dea_a[c] = 0; m_dea_s[c] = 0;
    end
  endtask

  // one clock: compute next reference state, advance, compare outputs
  task automatic tick();
    logic        n_run = m_run;
    logic [15:0] n_cnt = m_cnt, n_per_a = m_per_a, n_per_s = m_per_s;
    logic [15:0] n_act_a [6], n_act_s [6], n_dea_a [6], n_dea_s [6];
    logic [5:0]  n_out = m_out, n_ma = m_ma, n_md = m_md;
    logic [5:0]  clr_a = 0, clr_d = 0, set_a = 0, set_d = 0;
    for (int c = 0; c < 6; c++) begin
      n_act_a[c] = m_act_a[c]; n_act_s[c] = m_act_s[c];
      n_dea_a[c] = m_dea_a[c]; n_dea_s[c] = m_dea_s[c];
    end
    if (we_i) begin
      case (addr_i)
        A_CTRL: n_run = wdata_i[0];
        A_PER:  n_per_s = wdata_i[15:0];
        A_FLAG: begin clr_a = wdata_i[5:0]; clr_d = wdata_i[13:8]; end
        A_MASK: begin n_ma = wdata_i[5:0]; n_md = wdata_i[13:8]; end
        default: for (int c = 0; c < 6; c++) begin
          if (addr_i == A_ACT + 6'(c)) n_act_s[c] = wdata_i[15:0];
          if (addr_i == A_DEA + 6'(c)) n_dea_s[c] = wdata_i[15:0];
        end
      endcase
    end
    if (m_run) begin
      for (int c = 0; c < 6; c++) begin
        set_a[c] = (m_cnt == m_act_a[c]);
        set_d[c] = (m_cnt == m_dea_a[c]);
        if (set_d[c]) n_out[c] = 0;
        else if (set_a[c]) n_out[c] = 1;
      end
      if (m_cnt == m_per_a) begin
        n_cnt = 0; n_per_a = m_per_s;
        for (int c = 0; c < 6; c++) begin n_act_a[c] = m_act_s[c]; n_dea_a[c] = m_dea_s[c]; end
      end else n_cnt = m_cnt + 1;
    end else n_out = 0;
    @(posedge clk_i);
    @(negedge clk_i);
    m_run = n_run; m_cnt = n_cnt; m_per_a = n_per_a; m_per_s = n_per_s;
    m_out = n_out; m_ma = n_ma; m_md = n_md;
    m_fa = (m_fa & ~clr_a) | set_a;
    m_fd = (m_fd & ~clr_d) | set_d;
    for (int c = 0; c < 6; c++) begin
      m_act_a[c] = n_act_a[c]; m_act_s[c] = n_act_s[c];
      m_dea_a[c] = n_dea_a[c]; m_dea_s[c] = n_dea_s[c];
    end
    chk({26'b0, pwm_o}, {26'b0, m_out}, "R2 R3 R4 R5 pwm_o");
    chk({31'b0, irq_o}, {31'b0, exp_irq()}, "R7 R8 irq_o");
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    we_i = 1; addr_i = a; wdata_i = d;
    tick();
    we_i = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string what);
    addr_i = a;
    #1;
    chk(rdata_o, exp_rd(a), what);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] cnt_before;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    chk({26'b0, pwm_o}, 32'h0, "R2 pwm_o after reset");
    chk({31'b0, irq_o}, 32'h0, "R8 irq_o after reset");
    rd(A_CNT, "R1 counter after reset");
    rd(A_ACT + 6'd0, "R6 switch-on shadow after reset");
    rd(A_MASK, "R8 mask after reset");

    // directed setup
    wr(A_MASK, 32'h0000_3F3F);
    wr(A_PER, 32'd9);
    wr(A_ACT + 6'd0, 32'd2); wr(A_DEA + 6'd0, 32'd5);
    wr(A_ACT + 6'd1, 32'd7); wr(A_DEA + 6'd1, 32'd3);  // pulse wraps the period
    wr(A_ACT + 6'd2, 32'd4); wr(A_DEA + 6'd2, 32'd4);  // equal edges
    wr(A_ACT + 6'd3, 32'd0); wr(A_DEA + 6'd3, 32'd9);
    wr(A_CTRL, 32'd1);
    repeat (14) tick();
    rd(A_CNT, "R1 counter running");
    // mid-period rewrite: readback new, output keeps old until wrap (R5 R6)
    wr(A_ACT + 6'd0, 32'd6);
    rd(A_ACT + 6'd0, "R6 readback of shadow");
    repeat (25) begin tick(); rd(A_CNT, "R1 counter"); end
    chk({31'b0, pwm_o[2]}, 32'h0, "R4 equal edges keep output low");
    wr(A_ACT + 6'd3, 32'hFFFF_FFFF);
    rd(A_ACT + 6'd3, "R6 upper bits read zero");
    wr(A_ACT + 6'd3, 32'd1);
    rd(A_FLAG, "R3 R4 flags set");
    wr(A_FLAG, 32'h0000_3F3F);
    rd(A_FLAG, "R7 flags after clear");
    repeat (5) tick();
    // stop: counter held, outputs low
    wr(A_CTRL, 32'd0);
    cnt_before = m_cnt;
    repeat (6) tick();
    rd(A_CNT, "R2 counter held while stopped");
    chk({16'b0, rdata_o[15:0]}, {16'b0, cnt_before}, "R2 counter unchanged");
    chk({26'b0, pwm_o}, 32'h0, "R2 outputs low while stopped");
    wr(A_CTRL, 32'd1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [5:0] a;
        logic [31:0] d;
        case ($urandom_range(0, 9))
          0: begin a = A_CTRL; d = ($urandom_range(0, 9) != 0) ? 32'd1 : 32'd0; end
          1: begin a = A_PER;  d = $urandom_range(0, 30); end
          2: begin a = A_FLAG; d = $urandom; end
          3: begin a = A_MASK; d = $urandom; end
          4, 5, 6: begin a = A_ACT + 6'($urandom_range(0, 5)); d = {$urandom_range(0, 65535), 16'(($urandom_range(0, 31)))}; end
          default: begin a = A_DEA + 6'($urandom_range(0, 5)); d = {$urandom_range(0, 65535), 16'(($urandom_range(0, 31)))}; end
        endcase
        wr(a, d);
      end else tick();
      if (i % 7 == 0) begin
        logic [5:0] ra;
        case ($urandom_range(0, 4))
          0: ra = A_CNT;
          1: ra = A_FLAG;
          2: ra = A_PER;
          3: ra = A_ACT + 6'($urandom_range(0, 5));
          default: ra = A_DEA + 6'($urandom_range(0, 5));
        endcase
        rd(ra, "R1 R5 R6 R7 random readback");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule